// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and verifies even parity for a 32-bit multiplexed address/data bus with four command/byte-enable lines. Each cycle it takes the parity of the address/data and command/byte-enable values on the bus and registers it. The result is driven on the parity line in the following cycle whenever the block drove the bus in the cycle before. That one rule covers three cases: address phases the block initiates, read data the block returns as target, and a parked bus.

When another agent drives the bus, the registered parity is compared with the parity line sampled one clock later. The comparison is used only in two kinds of cycle:

- **Address phase.** This is the first cycle of FRAME# assertion. A mismatch sets a sticky address-error flag. The flag stays set until a clear pulse arrives.
- **Completed data phase.** This is a cycle with IRDY# and TRDY# both low. A mismatch pulses the active-low data-parity-error output. That output is driven high for one further cycle before its output-enable drops.

Top module: `bus_parity_unit`

## Requirements
- R1: While `par_oe_o` is 1, `par_o` makes the count of ones even over the previous cycle's `ad_i`, `cbe_i` and `par_o` itself.
- R2: `par_oe_o` is 1 exactly in the cycle after a cycle with `ad_oe_i` = 1. The parity line is therefore released one cycle after the address/data lines are released.
- R3: With the bus idle (FRAME# and IRDY# high) and `ad_oe_i` = 1 (parked), valid parity is driven every cycle.
- R4: The address phase is the first cycle with `frame_n_i` = 0 after a cycle with `frame_n_i` = 1, while `ad_oe_i` = 0. If, in the next cycle, `par_i` gives an odd count of ones over that phase's bits plus `par_i`, then `addr_err_o` is 1 from the following cycle on.
- R5: A completed data phase is a cycle with `irdy_n_i` = 0, `trdy_n_i` = 0 and `ad_oe_i` = 0. If `par_i` is wrong in the next cycle, `perr_n_o` is 0 for exactly one cycle, two cycles after the data phase. A single flipped bit among the 32 data, 4 enable or 1 parity bits is always detected.
- R6: When the block itself drove the data (`ad_oe_i` = 1 in the data phase), no data parity error is reported.
- R7: A data cycle with `trdy_n_i` = 1 or `irdy_n_i` = 1 never causes a data parity error.
- R8: Data phases never set `addr_err_o`. An address phase driven by the block (`ad_oe_i` = 1) never sets it either.
- R9: `addr_err_o` stays 1 until a cycle with `addr_err_clr_i` = 1. It is 0 from the next cycle on, unless a new address error is detected in that same cycle.
- R10: `perr_oe_o` is 1 while `perr_n_o` is 0 and for one cycle after, with `perr_n_o` = 1 in that extra cycle.
- R11: After reset, `par_oe_o` = 0, `perr_oe_o` = 0, `perr_n_o` = 1 and `addr_err_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ad_i | input | 32 | Address/data value present on the bus |
| cbe_i | input | 4 | Command/byte-enable value present on the bus |
| frame_n_i | input | 1 | FRAME#, active low |
| irdy_n_i | input | 1 | IRDY#, active low |
| trdy_n_i | input | 1 | TRDY#, active low |
| ad_oe_i | input | 1 | 1 when this side drives address/data this cycle |
| par_i | input | 1 | Sampled parity line |
| par_o | output | 1 | Parity value to drive |
| par_oe_o | output | 1 | Parity line output enable |
| addr_err_clr_i | input | 1 | Clear pulse for the address error flag |
| addr_err_o | output | 1 | Sticky address parity error flag |
| perr_n_o | output | 1 | Data parity error, active low |
| perr_oe_o | output | 1 | Output enable for `perr_n_o` |

## Verification
On every cycle, the assertions check the following:
- the driven parity value and its one-cycle-delayed enable;
- that a data error only follows a completed, received data phase two cycles earlier;
- that the error output is always driven high once before release;
- that the address flag holds until cleared.

Only the bench scenarios can show that a wrong parity is actually caught. They flip each of the 37 covered bits in turn, in both address and data phases. They also show that driven reads and stalled phases stay silent, and that parking keeps the line driven.

// File: rtl/bus_parity_pkg.sv
package bus_parity_pkg;

    // Qualified phase seen on the previous clock
    typedef struct packed {
        logic addr_ph;   // first cycle of FRAME# assertion
        logic data_ph;   // IRDY# and TRDY# both asserted
        logic received;  // another agent drove the bus
    } phase_flags_t;

    localparam phase_flags_t PHASE_NONE = '{addr_ph: 1'b0, data_ph: 1'b0, received: 1'b0};

    function automatic logic odd_ones(input logic a, input logic b);
        return a ^ b;
    endfunction

endpackage

// File: rtl/bpar_gen.sv
module bpar_gen #(
    parameter int AD_W = 32,
    parameter int BE_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AD_W-1:0] ad,
    input  logic [BE_W-1:0] cbe,
    input  logic            drive,
    output logic            par_q,
    output logic            oe_q
);
    localparam int LANES = AD_W / 8;

    logic [LANES-1:0] lane_par;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign lane_par[g] = ^ad[8*g +: 8];
        end
    endgenerate

    logic par_next;
    assign par_next = (^lane_par) ^ (^cbe);

    always_ff @(posedge clk) begin
        if (rst) begin
            par_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            par_q <= par_next;
            oe_q  <= drive;
        end
    end
endmodule

// File: rtl/bpar_phase.sv
module bpar_phase
    import bus_parity_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         frame_n,
    input  logic         irdy_n,
    input  logic         trdy_n,
    input  logic         ad_oe,
    output phase_flags_t flags_q
);
    logic frame_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_n_q <= 1'b1;
            flags_q   <= PHASE_NONE;
        end else begin
            frame_n_q        <= frame_n;
            flags_q.addr_ph  <= !frame_n && frame_n_q;
            flags_q.data_ph  <= !irdy_n && !trdy_n;
            flags_q.received <= !ad_oe;
        end
    end
endmodule

// File: rtl/bpar_chk.sv
module bpar_chk
    import bus_parity_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  phase_flags_t flags_q,
    input  logic         calc_par,
    input  logic         par_in,
    input  logic         clr,
    output logic         addr_err,
    output logic         perr_n,
    output logic         perr_oe
);
    logic mismatch;
    logic perr_q;
    logic perr_d1;

    assign mismatch = odd_ones(calc_par, par_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_err <= 1'b0;
            perr_q   <= 1'b0;
            perr_d1  <= 1'b0;
        end else begin
            if (flags_q.addr_ph && flags_q.received && mismatch)
                addr_err <= 1'b1;
            else if (clr)
                addr_err <= 1'b0;
            perr_q  <= flags_q.data_ph && flags_q.received && mismatch;
            perr_d1 <= perr_q;
        end
    end

    assign perr_n  = !perr_q;
    assign perr_oe = perr_q || perr_d1;

    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_err && !clr) |=> addr_err);
    // R10
    perr_high_before_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(perr_n) |-> perr_oe);
    // R10
    perr_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        !perr_oe |-> perr_n);
endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit
    import bus_parity_pkg::*;
#(
    parameter int AD_W = 32,
    parameter int BE_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AD_W-1:0] ad_i,
    input  logic [BE_W-1:0] cbe_i,
    input  logic            frame_n_i,
    input  logic            irdy_n_i,
    input  logic            trdy_n_i,
    input  logic            ad_oe_i,
    input  logic            par_i,
    output logic            par_o,
    output logic            par_oe_o,
    input  logic            addr_err_clr_i,
    output logic            addr_err_o,
    output logic            perr_n_o,
    output logic            perr_oe_o
);
    phase_flags_t flags;

    bpar_gen #(.AD_W(AD_W), .BE_W(BE_W)) u_gen (
        .clk   (clk),
        .rst   (rst),
        .ad    (ad_i),
        .cbe   (cbe_i),
        .drive (ad_oe_i),
        .par_q (par_o),
        .oe_q  (par_oe_o)
    );

    bpar_phase u_phase (
        .clk     (clk),
        .rst     (rst),
        .frame_n (frame_n_i),
        .irdy_n  (irdy_n_i),
        .trdy_n  (trdy_n_i),
        .ad_oe   (ad_oe_i),
        .flags_q (flags)
    );

    bpar_chk u_chk (
        .clk      (clk),
        .rst      (rst),
        .flags_q  (flags),
        .calc_par (par_o),
        .par_in   (par_i),
        .clr      (addr_err_clr_i),
        .addr_err (addr_err_o),
        .perr_n   (perr_n_o),
        .perr_oe  (perr_oe_o)
    );

    // R1
    even_drive_chk: assert property (@(posedge clk) disable iff (rst)
        par_oe_o |-> ((^{$past(ad_i), $past(cbe_i), par_o}) == 1'b0));
    // R2
    oe_follow_chk: assert property (@(posedge clk) disable iff (rst)
        ad_oe_i |=> par_oe_o);
    // R2
    oe_release_chk: assert property (@(posedge clk) disable iff (rst)
        !ad_oe_i |=> !par_oe_o);
    // R5
    perr_after_completed_chk: assert property (@(posedge clk) disable iff (rst)
        !perr_n_o |-> $past(!irdy_n_i && !trdy_n_i, 2));
    // R6
    perr_only_received_chk: assert property (@(posedge clk) disable iff (rst)
        !perr_n_o |-> $past(!ad_oe_i, 2));
endmodule

// File: tb/bus_parity_unit_tb.sv
module bus_parity_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] ad;
    logic [3:0]  cbe;
    logic        frame_n, irdy_n, trdy_n, ad_oe, par_in, clr;
    logic        par_o, par_oe_o, addr_err_o, perr_n_o, perr_oe_o;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    bus_parity_unit u_dut (
        .clk(clk), .rst(rst), .ad_i(ad), .cbe_i(cbe),
        .frame_n_i(frame_n), .irdy_n_i(irdy_n), .trdy_n_i(trdy_n),
        .ad_oe_i(ad_oe), .par_i(par_in), .par_o(par_o), .par_oe_o(par_oe_o),
        .addr_err_clr_i(clr), .addr_err_o(addr_err_o),
        .perr_n_o(perr_n_o), .perr_oe_o(perr_oe_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic even_bit(input logic [35:0] v);
        return logic'($countones(v) % 2);
    endfunction

    task automatic idle_inputs();
        ad = '0; cbe = '0; frame_n = 1'b1; irdy_n = 1'b1; trdy_n = 1'b1;
        ad_oe = 1'b0; par_in = 1'b0; clr = 1'b0;
    endtask

    // Address phase then one data phase.
    // aerr/derr: bit index 0..36 to corrupt (36 = parity itself), -1 = clean.
    task automatic transfer(input logic [35:0] av, input int aerr, input logic [35:0] dv,
                            input int derr, input logic trdy_ok, input logic we_drive,
                            input logic a_drive);
        logic [35:0] abus, dbus;
        logic exp_a, exp_d;
        abus = (aerr >= 0 && aerr < 36) ? av ^ (36'd1 << aerr) : av;
        dbus = (derr >= 0 && derr < 36) ? dv ^ (36'd1 << derr) : dv;
        exp_a = (aerr >= 0) && !a_drive;
        exp_d = (derr >= 0) && trdy_ok && !we_drive;
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; trdy_n = 1'b1; ad_oe = a_drive;
        {cbe, ad} = abus;
        @(negedge clk);
        par_in = even_bit(av) ^ (aerr == 36);
        frame_n = 1'b1; irdy_n = 1'b0; trdy_n = !trdy_ok; ad_oe = we_drive;
        {cbe, ad} = dbus;
        @(negedge clk);
        check("R4/R8 addr_err after address phase", addr_err_o, exp_a);
        par_in = even_bit(dv) ^ (derr == 36);
        irdy_n = 1'b1; trdy_n = 1'b1; ad_oe = 1'b0; ad = '0; cbe = '0;
        @(negedge clk);
        check("R5/R6/R7 perr_n low", perr_n_o, !exp_d);
        check("R10 perr_oe while low", perr_oe_o, exp_d);
        check("R8/R9 addr_err sticky", addr_err_o, exp_a);
        par_in = 1'b0; clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check("R10 perr_n high before release", perr_n_o, 1'b1);
        check("R10 perr_oe extra cycle", perr_oe_o, exp_d);
        check("R9 addr_err cleared", addr_err_o, 1'b0);
        @(negedge clk);
        check("R10 perr_oe released", perr_oe_o, 1'b0);
    endtask

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R11 par_oe reset", par_oe_o, 1'b0);
        check("R11 perr_oe reset", perr_oe_o, 1'b0);
        check("R11 perr_n reset", perr_n_o, 1'b1);
        check("R11 addr_err reset", addr_err_o, 1'b0);

        // R1 R2 R3: parked bus with varied patterns, then release
        for (int i = 0; i < 40; i++) begin
            logic [35:0] v;
            v = {4'(i * 3), 32'h9E3779B9 * (i + 1)};
            ad_oe = 1'b1; {cbe, ad} = v;
            @(negedge clk);
            check("R3 parked par_oe", par_oe_o, 1'b1);
            check("R1 parked parity value", par_o, even_bit(v));
        end
        ad_oe = 1'b0; ad = '0; cbe = '0;
        @(negedge clk);
        check("R2 par_oe released one cycle later", par_oe_o, 1'b0);

        // R4 R5: every single-bit corruption in address and in data phase
        for (int k = 0; k < 37; k++) begin
            transfer({4'h6, 32'h1000_0000 + 32'(k * 4)}, k, {4'h0, 32'hA5A5_0000 ^ 32'(k)},
                     -1, 1'b1, 1'b0, 1'b0);
            transfer({4'h7, 32'h2000_0000 + 32'(k * 8)}, -1, {4'hF, 32'h5A5A_FFFF ^ 32'(k << 7)},
                     k, 1'b1, 1'b0, 1'b0);
        end
        // clean transfers
        transfer({4'h6, 32'hDEAD_BEEF}, -1, {4'h3, 32'h0123_4567}, -1, 1'b1, 1'b0, 1'b0);
        // R7: data phase not completed
        transfer({4'h6, 32'h0000_0040}, -1, {4'h0, 32'hFFFF_0000}, 5, 1'b0, 1'b0, 1'b0);
        // R6: block drove the read data; also verify R1 on the driven data
        transfer({4'h6, 32'h0000_0080}, -1, {4'h0, 32'h1357_9BDF}, 12, 1'b1, 1'b1, 1'b0);
        // R8: block drove the address phase
        transfer({4'h7, 32'h0000_00C0}, 3, {4'h0, 32'h0}, -1, 1'b1, 1'b0, 1'b1);

        // R9: set wins over a simultaneous clear
        @(negedge clk);
        frame_n = 1'b0; ad = 32'h1; cbe = 4'h6;
        @(negedge clk);
        frame_n = 1'b1; ad = '0; cbe = '0; par_in = 1'b0; clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check("R9 set wins over clear", addr_err_o, 1'b1);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check("R9 clear", addr_err_o, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule